// File: doc/BRIEF.md
# Sleep Mode and Wake Controller

This block decides which clock domains of a small system keep running. While the system is Active, a one-cycle sleep request carries a 3-bit mode code. The block then moves into one of five low-power modes. Each mode switches off its own set of clock enables. The enables cover five domains: the processor, the non-volatile memory, a bank of peripherals, the real-time counter and the oscillators.

While asleep, the block watches five wake inputs. A wake input returns the system to Active only if the current mode accepts that source. Two of the modes stop the oscillators. A wake from either of them passes through a restart phase of programmable length before the processor clock returns. The modes that keep the oscillators running return to Active at once.

A per-peripheral power-reduction mask can hold any peripheral clock off in every state, including Active. Every output is a register.

Top module: `sleep_wake_ctrl`

## Requirements
- R1: While `rst` is high, and on the cycle after it falls, `pstate_o` is 0 (Active). The processor, memory, real-time counter and oscillator enables are 1, and `clk_en_per` equals the inverse of the sampled `pr_mask`.
- R2: In Active, a sampled `slp_req` with `slp_mode` 1 (Idle), 2 (Deep-off), 3 (RTC-keep), 4 (Osc-hold) or 5 (Osc-hold with RTC) sets `pstate_o` to that code, together with the matching enables, one cycle after the sampling edge.
- R3: A sleep request with mode code 0, 6 or 7 is ignored. The block stays in Active and its enables do not change.
- R4: A sleep request is ignored outside Active, that is, in any sleep state and during the restart phase (`pstate_o` = 6).
- R5: Idle turns off only the processor and memory enables. Any of the five wake inputs returns the block to Active on the next cycle.
- R6: Deep-off turns off all five kinds of enable. Only `wake_pin` or `wake_twi` wakes it; `wake_irq`, `wake_rtc_ovf` and `wake_rtc_cmp` are ignored.
- R7: RTC-keep behaves like Deep-off, with two differences. The real-time counter enable follows `rtc_en`. While `rtc_en` is 1, `wake_rtc_ovf` or `wake_rtc_cmp` also wakes the block.
- R8: Osc-hold keeps only the oscillator enable on and wakes on `wake_pin` or `wake_twi`. It returns to Active on the next cycle, whatever the value of `startup_cnt`.
- R9: Osc-hold with RTC keeps the oscillator enable on, drives the real-time counter enable from `rtc_en`, and accepts the same wake sources as RTC-keep. It returns to Active with no restart phase.
- R10: A wake from Deep-off or RTC-keep with `startup_cnt` = N > 0 holds `pstate_o` at 6 for exactly N cycles before Active. During that phase the oscillator and real-time counter enables are 1, and the processor, memory and peripheral enables are 0. With N = 0 the block goes straight to Active.
- R11: Bit i of `pr_mask` forces `clk_en_per[i]` to 0 in every state, one cycle after the mask is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| slp_req | input | 1 | Sleep request strobe |
| slp_mode | input | 3 | Requested mode code |
| startup_cnt | input | CNT_W | Restart phase length in cycles |
| rtc_en | input | 1 | Real-time counter enabled |
| pr_mask | input | NUM_PER | Peripheral power-reduction mask |
| wake_irq | input | 1 | Any enabled interrupt |
| wake_pin | input | 1 | Asynchronous pin interrupt |
| wake_twi | input | 1 | Two-wire address-match interrupt |
| wake_rtc_ovf | input | 1 | Real-time counter overflow |
| wake_rtc_cmp | input | 1 | Real-time counter compare match |
| clk_en_cpu | output | 1 | Processor clock enable |
| clk_en_nvm | output | 1 | Non-volatile memory clock enable |
| clk_en_per | output | NUM_PER | Peripheral clock enables |
| clk_en_rtc | output | 1 | Real-time counter clock enable |
| osc_en | output | 1 | Oscillator enable |
| pstate_o | output | 3 | Current state code (0 Active, 1-5 modes, 6 restart) |

## Verification
The bench holds sources that a mode must reject, such as an interrupt or RTC event in Deep-off, or an RTC event with `rtc_en` low in RTC-keep. A design with a loose wake qualifier would drop back to Active at that point. It also issues reserved codes and requests made during sleep and during the restart phase. A design that decoded these would gate clocks that should stay on. The restart phase is timed with lengths of zero, three and four cycles, and a large count is offered to the oscillator-holding modes. An off-by-one counter, or a delay applied to the wrong modes, would show up as a shifted return of the processor enable. Changes to the mask in Active and in Idle catch gating that ignores the mask in one state.

// File: rtl/slp_pkg.sv
package slp_pkg;

  typedef enum logic [2:0] {
    PS_ACT   = 3'd0,
    PS_IDLE  = 3'd1,
    PS_DOFF  = 3'd2,
    PS_RKEEP = 3'd3,
    PS_OHOLD = 3'd4,
    PS_OHRTC = 3'd5,
    PS_WAKE  = 3'd6
  } pstate_e;

  typedef struct packed {
    logic cpu;
    logic nvm;
    logic per;
    logic rtc;
    logic osc;
  } gate_s;

  function automatic gate_s gates_for(pstate_e s, logic rtc_on);
    gate_s g;
    g = '0;
    case (s)
      PS_ACT:   g = '{cpu: 1'b1, nvm: 1'b1, per: 1'b1, rtc: 1'b1, osc: 1'b1};
      PS_IDLE:  g = '{cpu: 1'b0, nvm: 1'b0, per: 1'b1, rtc: 1'b1, osc: 1'b1};
      PS_DOFF:  g = '{cpu: 1'b0, nvm: 1'b0, per: 1'b0, rtc: 1'b0, osc: 1'b0};
      PS_RKEEP: g = '{cpu: 1'b0, nvm: 1'b0, per: 1'b0, rtc: rtc_on, osc: 1'b0};
      PS_OHOLD: g = '{cpu: 1'b0, nvm: 1'b0, per: 1'b0, rtc: 1'b0, osc: 1'b1};
      PS_OHRTC: g = '{cpu: 1'b0, nvm: 1'b0, per: 1'b0, rtc: rtc_on, osc: 1'b1};
      PS_WAKE:  g = '{cpu: 1'b0, nvm: 1'b0, per: 1'b0, rtc: 1'b1, osc: 1'b1};
      default:  g = '0;
    endcase
    return g;
  endfunction

  function automatic logic needs_restart(pstate_e s);
    return (s == PS_DOFF) || (s == PS_RKEEP);
  endfunction

endpackage

// File: rtl/slp_mode_decode.sv
module slp_mode_decode
  import slp_pkg::*;
(
  input  logic [2:0] code,
  output pstate_e    target,
  output logic       valid
);
  always_comb begin
    valid  = 1'b1;
    target = PS_ACT;
    case (code)
      3'd1: target = PS_IDLE;
      3'd2: target = PS_DOFF;
      3'd3: target = PS_RKEEP;
      3'd4: target = PS_OHOLD;
      3'd5: target = PS_OHRTC;
      default: valid = 1'b0;
    endcase
  end
endmodule

// File: rtl/slp_wake_qual.sv
module slp_wake_qual
  import slp_pkg::*;
(
  input  pstate_e st,
  input  logic    rtc_en,
  input  logic    w_irq,
  input  logic    w_pin,
  input  logic    w_twi,
  input  logic    w_ovf,
  input  logic    w_cmp,
  output logic    wake
);
  logic async_src;
  logic rtc_src;

  always_comb begin
    async_src = w_pin | w_twi;
    rtc_src   = rtc_en & (w_ovf | w_cmp);
    case (st)
      PS_IDLE:            wake = w_irq | async_src | w_ovf | w_cmp;
      PS_DOFF, PS_OHOLD:  wake = async_src;
      PS_RKEEP, PS_OHRTC: wake = async_src | rtc_src;
      default:            wake = 1'b0;
    endcase
  end
endmodule

// File: rtl/slp_restart_timer.sv
module slp_restart_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             last
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                 cnt_q <= '0;
    else if (load)           cnt_q <= load_val;
    else if (cnt_q != '0)    cnt_q <= cnt_q - ONE;
  end

  assign last = (cnt_q == ONE);
endmodule

// File: rtl/slp_gate_map.sv
module slp_gate_map
  import slp_pkg::*;
#(
  parameter int NUM_PER = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  pstate_e            st_next,
  input  logic               rtc_en,
  input  logic [NUM_PER-1:0] pr_mask,
  output logic               en_cpu,
  output logic               en_nvm,
  output logic [NUM_PER-1:0] en_per,
  output logic               en_rtc,
  output logic               en_osc
);
  gate_s g_next;

  always_comb g_next = gates_for(rst ? PS_ACT : st_next, rtc_en);

  always_ff @(posedge clk) begin
    en_cpu <= g_next.cpu;
    en_nvm <= g_next.nvm;
    en_rtc <= g_next.rtc;
    en_osc <= g_next.osc;
  end

  for (genvar i = 0; i < NUM_PER; i++) begin : g_per
    always_ff @(posedge clk) begin
      en_per[i] <= g_next.per & ~pr_mask[i];
    end
  end
endmodule

// File: rtl/sleep_wake_ctrl.sv
module sleep_wake_ctrl
  import slp_pkg::*;
#(
  parameter int NUM_PER = 8,
  parameter int CNT_W   = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               slp_req,
  input  logic [2:0]         slp_mode,
  input  logic [CNT_W-1:0]   startup_cnt,
  input  logic               rtc_en,
  input  logic [NUM_PER-1:0] pr_mask,
  input  logic               wake_irq,
  input  logic               wake_pin,
  input  logic               wake_twi,
  input  logic               wake_rtc_ovf,
  input  logic               wake_rtc_cmp,
  output logic               clk_en_cpu,
  output logic               clk_en_nvm,
  output logic [NUM_PER-1:0] clk_en_per,
  output logic               clk_en_rtc,
  output logic               osc_en,
  output logic [2:0]         pstate_o
);
  pstate_e state_q, state_d;
  pstate_e req_target;
  logic    req_valid;
  logic    wake_ok;
  logic    tmr_load;
  logic    tmr_last;

  slp_mode_decode u_dec (
    .code   (slp_mode),
    .target (req_target),
    .valid  (req_valid)
  );

  slp_wake_qual u_wq (
    .st     (state_q),
    .rtc_en (rtc_en),
    .w_irq  (wake_irq),
    .w_pin  (wake_pin),
    .w_twi  (wake_twi),
    .w_ovf  (wake_rtc_ovf),
    .w_cmp  (wake_rtc_cmp),
    .wake   (wake_ok)
  );

  slp_restart_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk      (clk),
    .rst      (rst),
    .load     (tmr_load),
    .load_val (startup_cnt),
    .last     (tmr_last)
  );

  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    case (state_q)
      PS_ACT: begin
        if (slp_req && req_valid) state_d = req_target;
      end
      PS_WAKE: begin
        if (tmr_last) state_d = PS_ACT;
      end
      default: begin
        if (wake_ok) begin
          if (needs_restart(state_q) && (startup_cnt != '0)) begin
            state_d  = PS_WAKE;
            tmr_load = 1'b1;
          end else begin
            state_d = PS_ACT;
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= PS_ACT;
    else     state_q <= state_d;
  end

  slp_gate_map #(.NUM_PER(NUM_PER)) u_gm (
    .clk     (clk),
    .rst     (rst),
    .st_next (state_d),
    .rtc_en  (rtc_en),
    .pr_mask (pr_mask),
    .en_cpu  (clk_en_cpu),
    .en_nvm  (clk_en_nvm),
    .en_per  (clk_en_per),
    .en_rtc  (clk_en_rtc),
    .en_osc  (osc_en)
  );

  assign pstate_o = state_q;
endmodule

// File: rtl/sleep_wake_ctrl_chk.sv
module sleep_wake_ctrl_chk #(
  parameter int NUM_PER = 8
) (
  input logic               clk,
  input logic               rst,
  input logic               slp_req,
  input logic [2:0]         slp_mode,
  input logic [NUM_PER-1:0] pr_mask,
  input logic               wake_pin,
  input logic               wake_twi,
  input logic               clk_en_cpu,
  input logic [NUM_PER-1:0] clk_en_per,
  input logic               osc_en,
  input logic [2:0]         pstate_o
);
  // R1: reset returns to Active
  a_r1_reset_active: assert property (@(posedge clk) rst |=> (pstate_o == 3'd0));

  // R2: Idle request from Active lands in Idle
  a_r2_idle_entry: assert property (@(posedge clk) disable iff (rst)
    (pstate_o == 3'd0 && slp_req && slp_mode == 3'd1) |=> (pstate_o == 3'd1));

  // R3: reserved codes keep the block Active
  a_r3_reserved_ignored: assert property (@(posedge clk) disable iff (rst)
    (pstate_o == 3'd0 && slp_req && (slp_mode == 3'd0 || slp_mode >= 3'd6))
    |=> (pstate_o == 3'd0));

  // R5: processor clock is off in every non-Active state
  a_r5_cpu_off: assert property (@(posedge clk) disable iff (rst)
    (pstate_o != 3'd0) |-> !clk_en_cpu);

  // R6: Deep-off stays put without a pin or two-wire wake
  a_r6_doff_hold: assert property (@(posedge clk) disable iff (rst)
    (pstate_o == 3'd2 && !wake_pin && !wake_twi) |=> (pstate_o == 3'd2));

  // R8: oscillator-holding modes keep the oscillators running
  a_r8_osc_held: assert property (@(posedge clk) disable iff (rst)
    (pstate_o == 3'd4 || pstate_o == 3'd5) |-> osc_en);

  // R10: restart phase runs oscillators with the processor gated
  a_r10_restart_gates: assert property (@(posedge clk) disable iff (rst)
    (pstate_o == 3'd6) |-> (osc_en && !clk_en_cpu && clk_en_per == '0));

  // R11: a masked peripheral clock is off one cycle later
  a_r11_mask_forces: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((clk_en_per & $past(pr_mask)) == '0));
endmodule

bind sleep_wake_ctrl sleep_wake_ctrl_chk #(.NUM_PER(NUM_PER)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .slp_req    (slp_req),
  .slp_mode   (slp_mode),
  .pr_mask    (pr_mask),
  .wake_pin   (wake_pin),
  .wake_twi   (wake_twi),
  .clk_en_cpu (clk_en_cpu),
  .clk_en_per (clk_en_per),
  .osc_en     (osc_en),
  .pstate_o   (pstate_o)
);

// File: tb/sim_sleep_wake_ctrl.sv
`timescale 1ns/1ps
module sim_sleep_wake_ctrl;
  localparam int NP = 8;
  localparam int CW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          slp_req = 1'b0;
  logic [2:0]    slp_mode = 3'd0;
  logic [CW-1:0] startup_cnt = '0;
  logic          rtc_en = 1'b0;
  logic [NP-1:0] pr_mask = '0;
  logic          wake_irq = 1'b0, wake_pin = 1'b0, wake_twi = 1'b0;
  logic          wake_rtc_ovf = 1'b0, wake_rtc_cmp = 1'b0;
  logic          clk_en_cpu, clk_en_nvm, clk_en_rtc, osc_en;
  logic [NP-1:0] clk_en_per;
  logic [2:0]    pstate_o;

  always #2.5 clk = ~clk;

  sleep_wake_ctrl #(.NUM_PER(NP), .CNT_W(CW)) u0 (.*);

  int    n_chk = 0;
  int    n_fail = 0;
  string tag = "R1";
  bit    done = 1'b0;

  // behavioural reference
  int            m_st = 0;
  int            m_cnt = 0;
  logic          e_cpu = 1, e_nvm = 1, e_rtc = 1, e_osc = 1;
  logic [NP-1:0] e_per = '1;

  always @(posedge clk) begin
    bit w;
    if (rst) begin
      m_st = 0; m_cnt = 0;
    end else begin
      case (m_st)
        0: if (slp_req && slp_mode >= 3'd1 && slp_mode <= 3'd5) m_st = int'(slp_mode);
        6: begin m_cnt = m_cnt - 1; if (m_cnt == 0) m_st = 0; end
        default: begin
          if (m_st == 1) w = wake_irq | wake_pin | wake_twi | wake_rtc_ovf | wake_rtc_cmp;
          else w = wake_pin | wake_twi |
                   ((m_st == 3 || m_st == 5) && rtc_en && (wake_rtc_ovf | wake_rtc_cmp));
          if (w) begin
            if ((m_st == 2 || m_st == 3) && startup_cnt != 0) begin
              m_st = 6; m_cnt = int'(startup_cnt);
            end else m_st = 0;
          end
        end
      endcase
    end
    e_cpu = (m_st == 0);
    e_nvm = (m_st == 0);
    e_per = (m_st == 0 || m_st == 1) ? ~pr_mask : '0;
    e_rtc = (m_st == 0 || m_st == 1 || m_st == 6) || ((m_st == 3 || m_st == 5) && rtc_en);
    e_osc = (m_st == 0 || m_st == 1 || m_st == 4 || m_st == 5 || m_st == 6);
  end

  task automatic chk(string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual %0d expected %0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      chk("pstate", int'(pstate_o), m_st);
      chk("cpu", int'(clk_en_cpu), int'(e_cpu));
      chk("nvm", int'(clk_en_nvm), int'(e_nvm));
      chk("per", int'(clk_en_per), int'(e_per));
      chk("rtc", int'(clk_en_rtc), int'(e_rtc));
      chk("osc", int'(osc_en), int'(e_osc));
    end
  end

  task automatic cyc(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic req(logic [2:0] m);
    @(negedge clk); slp_req = 1'b1; slp_mode = m;
    @(negedge clk); slp_req = 1'b0; slp_mode = 3'd0;
  endtask

  task automatic pulse(ref logic s);
    @(negedge clk); s = 1'b1;
    @(negedge clk); s = 1'b0;
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #100000;
    n_fail++;
    $display("FAIL watchdog expired, actual running expected finished");
    finish_run();
  end

  initial begin
    tag = "R1"; cyc(3); @(negedge clk); rst = 1'b0; cyc(2);
    tag = "R3"; req(3'd0); cyc(1); req(3'd6); cyc(1); req(3'd7); cyc(2);
    tag = "R2"; req(3'd1); cyc(2);
    tag = "R4"; req(3'd2); cyc(2);
    tag = "R11"; @(negedge clk); pr_mask = 8'hA5; cyc(2);
    tag = "R5"; pulse(wake_irq); cyc(2);
    tag = "R11"; @(negedge clk); pr_mask = 8'h3C; cyc(2); pr_mask = '0;
    tag = "R6"; startup_cnt = 0; rtc_en = 1'b1; req(3'd2);
    pulse(wake_irq); pulse(wake_rtc_ovf); pulse(wake_rtc_cmp); cyc(2);
    pulse(wake_twi); cyc(2);
    tag = "R10"; startup_cnt = 4; req(3'd2); cyc(2); pulse(wake_pin); cyc(6);
    tag = "R7"; rtc_en = 1'b0; startup_cnt = 3; req(3'd3);
    pulse(wake_rtc_cmp); pulse(wake_irq); cyc(1);
    @(negedge clk); rtc_en = 1'b1; cyc(2); pulse(wake_rtc_ovf);
    tag = "R4"; req(3'd1); cyc(4);
    tag = "R10"; startup_cnt = 0; req(3'd3); pulse(wake_pin); cyc(2);
    tag = "R8"; startup_cnt = 16'd500; rtc_en = 1'b1; req(3'd4);
    pulse(wake_irq); pulse(wake_rtc_ovf); cyc(1); pulse(wake_pin); cyc(2);
    tag = "R9"; req(3'd5); pulse(wake_irq); @(negedge clk); rtc_en = 1'b0;
    pulse(wake_rtc_cmp); @(negedge clk); rtc_en = 1'b1; cyc(1);
    pulse(wake_rtc_cmp); cyc(2);
    tag = "R11"; @(negedge clk); pr_mask = 8'hFF; cyc(2); pr_mask = 8'h01; cyc(3);
    finish_run();
  end
endmodule